// File: doc/BRIEF.md
# SPI Master Shift Engine

This block is the serial core of an SPI master. It takes parallel words from a transmit queue, shifts them out on `mosi`, and samples `miso` into words that it pushes toward a receive queue. It makes the serial clock from the system clock through a programmable even divider. It drives two active-low chip-select lines from a one-hot select value. The queue storage, the interrupt logic and the register decoding sit outside the block.

The surrounding logic sets the control word, the divider and the select value while `en` is low, then raises `en`. From then on, every word offered on `tx_data` with `tx_valid` is consumed with a one-cycle `tx_pop` pulse and sent as one full-duplex frame. Each frame pushes exactly one received word with a one-cycle `rx_valid` pulse. If the next word is already waiting when a frame closes, the chip select stays asserted and frames run back to back.

Top module: `spi_shift_core`

## Requirements
- R1: Bit 7 of `ctrl_word` is the clock polarity. Whenever no chip select is asserted, `sclk` equals that bit.
- R2: Bit 6 of `ctrl_word` is the clock phase, and data is most significant bit first. With phase 0, `mosi` holds each bit before its leading `sclk` edge and `miso` is sampled on the leading edge. With phase 1, `mosi` changes on the leading edge and `miso` is sampled on the trailing edge. Mode 0 sets neither bit, mode 1 sets phase only, mode 2 sets polarity only and mode 3 sets both.
- R3: `ctrl_word[1:0]` picks the frame length: 0 gives 4 bits, 1 gives 8, 2 gives 16, and 3 is treated as 8. Only the low frame-length bits of `tx_data` are sent. `rx_data` is right-aligned with its upper bits zero.
- R4: The half period of `sclk` is `div_val >> 1` system cycles, and 1 when that value is 0, so bit 0 of `div_val` is ignored. Each frame has exactly twice the frame length of `sclk` edges.
- R5: The first `sclk` edge comes one half period after the chip select asserts. The chip select is released one half period after the last edge of the last frame.
- R6: A transfer starts only when `sel` is one-hot. `sel[0]` drives `cs_n[0]` low and `sel[1]` drives `cs_n[1]` low. A `sel` of 0 or 3 starts nothing.
- R7: While `en` is 0 no word is popped and no frame starts. Dropping `en` mid-frame aborts it: from the next cycle both chip selects are high, `sclk` is at its idle level and `busy` is 0.
- R8: Each frame pushes exactly one received word. `rx_valid` is high for one cycle, namely the cycle after the last `sclk` edge.
- R9: `busy` is 1 from the cycle a frame starts until its last `sclk` edge, and 0 when idle.
- R10: Each accepted word gives exactly one `tx_pop` pulse. When the next word is waiting at the end of a frame, the chip select stays asserted between frames, and the next first edge comes two half periods after the previous last edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | 8 | Polarity in bit 7, phase in bit 6, frame length code in bits 1:0 |
| en | input | 1 | Engine enable |
| sel | input | 2 | One-hot device select |
| div_val | input | 16 | Clock divider value |
| tx_valid | input | 1 | A transmit word is available |
| tx_data | input | 16 | Transmit word, right-aligned |
| tx_pop | output | 1 | Transmit word consumed this cycle |
| rx_valid | output | 1 | Received word valid for one cycle |
| rx_data | output | 16 | Received word, right-aligned |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 2 | Active-low chip selects |
| busy | output | 1 | Frame in progress |

## Verification
The assertions assume that `ctrl_word`, `div_val` and `sel` change only while `en` is low. The idle-level and clock-spacing properties would otherwise flag legitimate changes of polarity or divider. The bench reconfigures only after it has lowered `en` and waited a cycle. It keeps `tx_data` stable until it has seen the `tx_pop` pulse. A slave model in the bench answers on `miso` in step with the observed `sclk` edges and never changes `miso` in the cycle the engine samples it.

// File: rtl/spi_core_pkg.sv
package spi_core_pkg;
  localparam int DATA_W = 16;
  localparam int CPOL_BIT = 7;
  localparam int CPHA_BIT = 6;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_HOLD  = 2'd2
  } seq_state_e;

  // frame length in bits from the 2-bit size code
  function automatic logic [4:0] frame_bits(input logic [1:0] code);
    case (code)
      2'd0:    return 5'd4;
      2'd2:    return 5'd16;
      default: return 5'd8;
    endcase
  endfunction
endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);
  localparam int HALF_W = DIV_W - 1;

  logic [HALF_W-1:0] half_len;
  logic [HALF_W-1:0] cnt_q, cnt_d;

  // odd values round down, zero becomes one system cycle per half period
  always_comb begin
    half_len = div_val[DIV_W-1:1];
    if (half_len == '0) half_len = HALF_W'(1);
  end

  assign tick = run && (cnt_q == half_len - HALF_W'(1));

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + HALF_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter
  import spi_core_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] tx_word,
  input  logic [4:0]        nbits,
  input  logic              cpha,
  input  logic              drive_en,
  input  logic              sample_en,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_word
);
  logic [DATA_W-1:0] tx_sr_q, tx_sr_d;
  logic [DATA_W-1:0] rx_sr_q, rx_sr_d;
  logic              mosi_q, mosi_d;
  logic [DATA_W-1:0] aligned;
  logic [4:0]        pad;

  always_comb begin
    pad     = 5'(DATA_W) - nbits;
    aligned = tx_word << pad;
  end

  always_comb begin
    tx_sr_d = tx_sr_q;
    rx_sr_d = rx_sr_q;
    mosi_d  = mosi_q;
    if (load) begin
      rx_sr_d = '0;
      if (cpha) begin
        tx_sr_d = aligned;
      end else begin
        mosi_d  = aligned[DATA_W-1];
        tx_sr_d = aligned << 1;
      end
    end else begin
      if (drive_en) begin
        mosi_d  = tx_sr_q[DATA_W-1];
        tx_sr_d = tx_sr_q << 1;
      end
      if (sample_en) rx_sr_d = {rx_sr_q[DATA_W-2:0], miso};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr_q <= '0;
      rx_sr_q <= '0;
      mosi_q  <= 1'b0;
    end else begin
      tx_sr_q <= tx_sr_d;
      rx_sr_q <= rx_sr_d;
      mosi_q  <= mosi_d;
    end
  end

  assign mosi    = mosi_q;
  assign rx_word = rx_sr_q;
endmodule

// File: rtl/spi_seq.sv
module spi_seq
  import spi_core_pkg::*;
#(
  parameter int NUM_CS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tx_valid,
  input  logic [NUM_CS-1:0] sel,
  input  logic              tick,
  input  logic [4:0]        nbits,
  input  logic              cpha,
  output logic              load,
  output logic              run,
  output logic              busy,
  output logic              drive_en,
  output logic              sample_en,
  output logic              lvl,
  output logic              rx_push
);
  localparam int EDGE_W = $clog2(2 * DATA_W) + 1;

  seq_state_e        state_q, state_d;
  logic [EDGE_W-1:0] edge_q, edge_d;
  logic              lvl_q, lvl_d;
  logic              push_q, push_d;
  logic [EDGE_W-1:0] last_edge;
  logic              sel_ok, shift_tick, leading;

  always_comb begin
    sel_ok     = (sel != '0) && ((sel & (sel - NUM_CS'(1))) == '0);
    last_edge  = EDGE_W'({nbits, 1'b0}) - EDGE_W'(1);
    shift_tick = (state_q == ST_SHIFT) && tick;
    leading    = !edge_q[0];
    drive_en   = shift_tick && (cpha ? leading : !leading);
    sample_en  = shift_tick && (cpha ? !leading : leading);
  end

  always_comb begin
    state_d = state_q;
    edge_d  = edge_q;
    lvl_d   = lvl_q;
    push_d  = 1'b0;
    load    = 1'b0;
    if (!en) begin
      state_d = ST_IDLE;
      edge_d  = '0;
      lvl_d   = 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (tx_valid && sel_ok) begin
            load    = 1'b1;
            state_d = ST_SHIFT;
            edge_d  = '0;
            lvl_d   = 1'b0;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            lvl_d  = !lvl_q;
            edge_d = edge_q + EDGE_W'(1);
            if (edge_q == last_edge) begin
              state_d = ST_HOLD;
              push_d  = 1'b1;
            end
          end
        end
        ST_HOLD: begin
          if (tick) begin
            edge_d = '0;
            if (tx_valid) begin
              load    = 1'b1;
              state_d = ST_SHIFT;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      edge_q  <= '0;
      lvl_q   <= 1'b0;
      push_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      edge_q  <= edge_d;
      lvl_q   <= lvl_d;
      push_q  <= push_d;
    end
  end

  assign run     = (state_q != ST_IDLE);
  assign busy    = (state_q == ST_SHIFT);
  assign lvl     = lvl_q;
  assign rx_push = push_q;
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
  import spi_core_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int NUM_CS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        ctrl_word,
  input  logic              en,
  input  logic [NUM_CS-1:0] sel,
  input  logic [DIV_W-1:0]  div_val,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_pop,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] cs_n,
  output logic              busy
);
  logic       cpol, cpha;
  logic [4:0] nbits;
  logic       tick, run, load, drive_en, sample_en, lvl;

  assign cpol  = ctrl_word[CPOL_BIT];
  assign cpha  = ctrl_word[CPHA_BIT];
  assign nbits = frame_bits(ctrl_word[1:0]);

  spi_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .div_val (div_val),
    .tick    (tick)
  );

  spi_seq #(.NUM_CS(NUM_CS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .tx_valid  (tx_valid),
    .sel       (sel),
    .tick      (tick),
    .nbits     (nbits),
    .cpha      (cpha),
    .load      (load),
    .run       (run),
    .busy      (busy),
    .drive_en  (drive_en),
    .sample_en (sample_en),
    .lvl       (lvl),
    .rx_push   (rx_valid)
  );

  spi_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .tx_word   (tx_data),
    .nbits     (nbits),
    .cpha      (cpha),
    .drive_en  (drive_en),
    .sample_en (sample_en),
    .miso      (miso),
    .mosi      (mosi),
    .rx_word   (rx_data)
  );

  assign tx_pop = load;
  assign sclk   = cpol ^ lvl;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign cs_n[i] = !(run && sel[i]);
  end
endmodule

// File: rtl/spi_shift_core_chk.sv
module spi_shift_core_chk #(
  parameter int DIV_W  = 16,
  parameter int NUM_CS = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        ctrl_word,
  input logic              en,
  input logic [DIV_W-1:0]  div_val,
  input logic              tx_pop,
  input logic              rx_valid,
  input logic              sclk,
  input logic [NUM_CS-1:0] cs_n,
  input logic              busy
);
  assert_idle_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n == {NUM_CS{1'b1}}) |-> (sclk == ctrl_word[7]));

  assert_half_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && (div_val[DIV_W-1:2] != '0) && (sclk != $past(sclk))) |=> $stable(sclk));

  assert_cs_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  assert_no_pop_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !tx_pop);

  assert_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ((cs_n == {NUM_CS{1'b1}}) && !busy));

  assert_rx_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_edge_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && (sclk != $past(sclk))) |-> $past(busy));

  assert_pop_starts_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |=> busy);
endmodule

bind spi_shift_core spi_shift_core_chk #(.DIV_W(DIV_W), .NUM_CS(NUM_CS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctrl_word (ctrl_word),
  .en        (en),
  .div_val   (div_val),
  .tx_pop    (tx_pop),
  .rx_valid  (rx_valid),
  .sclk      (sclk),
  .cs_n      (cs_n),
  .busy      (busy)
);

// File: tb/spi_shift_core_test.sv
module spi_shift_core_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  ctrl_word;
  logic        en;
  logic [1:0]  sel;
  logic [15:0] div_val;
  logic        tx_valid;
  logic [15:0] tx_data;
  logic        tx_pop, rx_valid, sclk, mosi, busy;
  logic        miso;
  logic [15:0] rx_data;
  logic [1:0]  cs_n;

  always #5 clk = ~clk;

  spi_shift_core uut (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .en(en), .sel(sel),
    .div_val(div_val), .tx_valid(tx_valid), .tx_data(tx_data), .tx_pop(tx_pop),
    .rx_valid(rx_valid), .rx_data(rx_data), .sclk(sclk), .mosi(mosi),
    .miso(miso), .cs_n(cs_n), .busy(busy)
  );

  int checks = 0;
  int errors = 0;

  task automatic check_eq(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int fbits(input logic [1:0] code);
    return (code == 2'd0) ? 4 : (code == 2'd2) ? 16 : 8;
  endfunction

  function automatic int half_of(input logic [15:0] dv);
    return (dv < 16'd2) ? 1 : int'(dv >> 1);
  endfunction

  // expected configuration, written by the tasks while en is low
  int          nb = 8, exp_half = 1, m_words = 0;
  logic        exp_cpha = 1'b0;
  logic [1:0]  exp_sel = 2'b01;
  logic        drive_on = 1'b0;
  logic [15:0] words [8];
  logic [15:0] resp  [8];
  logic [15:0] cap   [8];
  logic [15:0] rxw   [8];

  // monitor state
  int   cyc = 0, e = 0, cs_cyc = 0, last_cyc = 0, idx = 0, pops = 0, rxn = 0;
  int   cs_asserts = 0, first_bad = 0, gap_bad = 0, rel_bad = 0, busy_bad = 0, cs_bad = 0, rxv_bad = 0;
  logic prev_cs = 1'b0, prev_sclk = 1'b0, prev_busy = 1'b0, pop_seen = 1'b0;

  task automatic clear_mon();
    e = 0; idx = 0; pops = 0; rxn = 0; cs_asserts = 0; first_bad = 0; gap_bad = 0;
    rel_bad = 0; busy_bad = 0; cs_bad = 0; rxv_bad = 0; pop_seen = 1'b0;
  endtask

  // slave model, queue driver and timing monitor, all away from the active edge
  always @(negedge clk) begin
    int s, f, k;
    logic cs_act;
    cyc++;
    cs_act = (cs_n != 2'b11);
    if (cs_act && !prev_cs) begin cs_asserts++; e = 0; cs_cyc = cyc; end
    if (!cs_act && prev_cs && e > 0 && (cyc - last_cyc) != exp_half) rel_bad++;
    if (cs_act && cs_n != ~exp_sel) cs_bad++;
    if (cs_act && sclk != prev_sclk) begin
      if (e == 0) begin
        if ((cyc - cs_cyc) != exp_half) first_bad++;
      end else if ((e % (2 * nb)) == 0) begin
        if ((cyc - last_cyc) != 2 * exp_half) gap_bad++;
      end else if ((cyc - last_cyc) != exp_half) gap_bad++;
      if (!prev_busy) busy_bad++;
      if (((e % 2) == 0) != exp_cpha) begin
        f = e / (2 * nb);
        k = (e % (2 * nb)) / 2;
        if (f < 8) cap[f][nb-1-k] = mosi;
      end
      e++;
      last_cyc = cyc;
    end
    if (cs_act) begin
      if (exp_cpha) s = ((e % 2) == 0) ? e + 1 : e;
      else          s = ((e % 2) == 0) ? e : e + 1;
      f = s / (2 * nb);
      k = (s % (2 * nb)) / 2;
      miso = (f < 8) ? resp[f][nb-1-k] : 1'b0;
    end
    if (rx_valid) begin
      if (cyc != last_cyc) rxv_bad++;
      if (rxn < 8) rxw[rxn] = rx_data;
      rxn++;
    end
    prev_cs = cs_act; prev_sclk = sclk; prev_busy = busy;
    if (pop_seen) idx++;
    tx_valid = drive_on && (idx < m_words);
    tx_data  = (idx < 8) ? words[idx] : 16'h0;
    #1;
    pop_seen = tx_pop;
    if (tx_pop) pops++;
  end

  task automatic setup(input logic [1:0] mode, input logic [1:0] fs, input logic [15:0] dv,
                       input logic [1:0] s, input int m);
    en = 1'b0; drive_on = 1'b0;
    @(negedge clk); @(negedge clk);
    ctrl_word = {mode[1], mode[0], 4'b0000, fs};
    div_val = dv; sel = s;
    nb = fbits(fs); exp_half = half_of(dv); exp_cpha = mode[0]; exp_sel = s; m_words = m;
    for (int i = 0; i < 8; i++) begin
      words[i] = 16'($urandom);
      resp[i]  = 16'($urandom) & 16'((32'd1 << nb) - 1);
      cap[i]   = 16'h0;
      rxw[i]   = 16'h0;
    end
    clear_mon();
    @(negedge clk);
    drive_on = 1'b1;
  endtask

  task automatic xfer(input logic [1:0] mode, input logic [1:0] fs, input logic [15:0] dv,
                      input logic [1:0] s, input int m);
    logic [15:0] msk;
    bit done;
    setup(mode, fs, dv, s, m);
    msk = 16'((32'd1 << nb) - 1);
    en = 1'b1;
    done = 0;
    for (int t = 0; t < 8000 && !done; t++) begin
      @(negedge clk);
      if (idx >= m && rxn >= m && cs_n == 2'b11) done = 1;
    end
    repeat (3) @(negedge clk);
    check_eq("R8", "transfer completes", done, 1);
    check_eq("R10", "pop count", pops, m);
    check_eq("R8", "receive push count", rxn, m);
    check_eq("R10", "chip select asserted once", cs_asserts, 1);
    check_eq("R4", "edge count", e, 2 * nb * m);
    for (int i = 0; i < m; i++) begin
      check_eq("R2", $sformatf("mosi word %0d mode %0d size %0d", i, mode, fs), cap[i], words[i] & msk);
      check_eq("R3", $sformatf("rx word %0d mode %0d size %0d", i, mode, fs), rxw[i], resp[i]);
    end
    check_eq("R5", "first edge delay faults", first_bad, 0);
    check_eq("R5", "release delay faults", rel_bad, 0);
    check_eq("R4", "edge spacing faults", gap_bad, 0);
    check_eq("R9", "edges outside busy", busy_bad, 0);
    check_eq("R6", "wrong chip select", cs_bad, 0);
    check_eq("R8", "rx_valid timing faults", rxv_bad, 0);
    check_eq("R9", "busy idle after transfer", busy, 0);
    check_eq("R1", "sclk idle level", sclk, mode[1]);
    en = 1'b0; drive_on = 1'b0;
  endtask

  task automatic no_start(input logic [1:0] s, input logic en_val, input string req);
    setup(2'd0, 2'd1, 16'd4, s, 1);
    en = en_val;
    repeat (40) @(negedge clk);
    check_eq(req, $sformatf("pops with sel=%0d en=%0d", s, en_val), pops, 0);
    check_eq(req, $sformatf("cs_n with sel=%0d en=%0d", s, en_val), cs_n, 2'b11);
    check_eq(req, "sclk stays idle", sclk, 1'b0);
    en = 1'b0; drive_on = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog expired actual=%0d expected=0", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; en = 1'b0; sel = 2'b01; ctrl_word = 8'h00; div_val = 16'd4;
    tx_valid = 1'b0; tx_data = 16'h0; miso = 1'b0;
    repeat (3) @(negedge clk);
    check_eq("R1", "reset cs_n", cs_n, 2'b11);
    check_eq("R1", "reset sclk", sclk, 1'b0);
    check_eq("R9", "reset busy", busy, 0);
    check_eq("R8", "reset rx_valid", rx_valid, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // directed corners
    no_start(2'b00, 1'b1, "R6");
    no_start(2'b11, 1'b1, "R6");
    no_start(2'b01, 1'b0, "R7");
    xfer(2'd0, 2'd1, 16'd0, 2'b01, 1);   // divider floor R4
    xfer(2'd1, 2'd0, 16'd1, 2'b10, 3);   // 4-bit frames, odd divider
    xfer(2'd2, 2'd2, 16'd5, 2'b01, 2);   // 16-bit, odd rounds down
    xfer(2'd3, 2'd3, 16'd6, 2'b10, 2);   // reserved code acts as 8-bit
    xfer(2'd0, 2'd2, 16'd2, 2'b01, 4);   // back to back R10

    // abort mid-frame R7
    setup(2'd2, 2'd2, 16'd8, 2'b01, 1);
    en = 1'b1;
    repeat (30) @(negedge clk);
    check_eq("R7", "frame running before abort", busy, 1);
    en = 1'b0;
    @(negedge clk);
    check_eq("R7", "abort cs_n", cs_n, 2'b11);
    check_eq("R7", "abort busy", busy, 0);
    check_eq("R7", "abort sclk idle high", sclk, 1'b1);
    repeat (40) @(negedge clk);
    check_eq("R7", "no push after abort", rxn, 0);
    drive_on = 1'b0;

    // constrained random
    for (int n = 0; n < 16; n++) begin
      logic [1:0] md, fs, sl;
      logic [15:0] dv;
      int m;
      md = 2'($urandom % 4);
      fs = 2'($urandom % 4);
      dv = 16'($urandom % 10);
      sl = ($urandom % 2) ? 2'b01 : 2'b10;
      m  = 1 + int'($urandom % 4);
      xfer(md, fs, dv, sl, m);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule